// File: doc/BRIEF.md
# Video Frame Packet Scheduler

This block turns programmable raster timing into the ordered stream of packet commands that a display serial link needs in video mode. Each raster line becomes six packet commands: a sync short packet, a blanking long packet covering the horizontal sync width, an hsync end short packet, a blanking long packet covering the back porch, an active segment, and a blanking long packet covering the front porch. The active segment is a pixel stream on active lines and blanking elsewhere. A downstream packet assembler takes each command through a valid/ready handshake and encodes it.

Timing values and the pixel format are ordinary inputs. The block copies them into shadow registers only when the first packet of a frame is accepted, so software may rewrite them at any time without tearing the frame in flight. The block also reports the line being scheduled, a count of completed frames, a pulse marking the start of each frame and a pixel-fetch request while a pixel stream command is offered.

Top module: `vid_pkt_sched`

## Requirements
- R1: While reset is asserted pkt_valid is 0, line_idx is 0 and frame_cnt is 0; the first command offered after reset is a vsync start (data type 0x01) on line 0.
- R2: Each line carries six commands in this order: sync start, blanking (data type 0x19, long) of hsync-width bytes, hsync end (data type 0x31, short), blanking of back-porch bytes, active segment, blanking of front-porch bytes.
- R3: The sync start of line 0 is vsync start 0x01; of line equal to the vertical sync width it is vsync end 0x11; of every other line it is hsync start 0x21; line 0 wins when both match. All short commands carry 0 in pkt_field.
- R4: The active segment is a pixel stream when the line index is at least vsync+vback and below vsync+vback+vactive; otherwise it is blanking; its byte count is hactive pixels.
- R5: With cfg_fmt24 = 0 a pixel is 2 bytes and the pixel stream type is 0x0E; with cfg_fmt24 = 1 a pixel is 3 bytes and the type is 0x3E. Every long command's pkt_field is its pixel count times bytes per pixel.
- R6: A frame has vsync+vback+vactive+vfront lines; line_idx gives the line of the offered command; frame_cnt increments by one, modulo 2^FW, when the last command of a frame is accepted, and line_idx returns to 0 at the same time.
- R7: Configuration inputs are captured only in the cycle the vsync start command is accepted; changes at any other time have no effect until the next frame.
- R8: While pkt_valid is 1 and pkt_ready is 0, the offered command holds unchanged and no command is skipped.
- R9: frame_start is 1 exactly in the cycle a vsync start command is accepted.
- R10: pix_req is 1 exactly while the offered command is a pixel stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hsync | input | HW | Horizontal sync width in pixels |
| cfg_hbp | input | HW | Horizontal back porch in pixels |
| cfg_hact | input | HW | Active pixels per line |
| cfg_hfp | input | HW | Horizontal front porch in pixels |
| cfg_vsync | input | VW | Vertical sync width in lines |
| cfg_vbp | input | VW | Vertical back porch in lines |
| cfg_vact | input | VW | Active lines |
| cfg_vfp | input | VW | Vertical front porch in lines |
| cfg_fmt24 | input | 1 | Pixel format: 0 = 16-bit, 1 = 24-bit |
| pkt_valid | output | 1 | Command offered |
| pkt_ready | input | 1 | Assembler accepts the command |
| pkt_dtype | output | 6 | Packet data type |
| pkt_long | output | 1 | 1 = long packet |
| pkt_field | output | 16 | Byte count for long, data bytes (zero) for short |
| pix_req | output | 1 | Pixel fetch request |
| frame_start | output | 1 | Pulse when a frame's first command is accepted |
| line_idx | output | VW+2 | Line of the offered command |
| frame_cnt | output | FW | Completed frames |

## Verification
Two events can land on the same clock edge: the acceptance of a frame's vsync start, which captures the configuration, and a rewrite of the configuration inputs. The bench changes the timing and the pixel format exactly in that acceptance cycle, and separately in the middle of a frame, and its reference model takes the values present at the accepting edge only. The next frame's byte counts and pixel type then show which values were captured. A second collision is the frame wrap under a stalled handshake, provoked with a sparse ready pattern across the last front-porch command.

// File: rtl/vps_pkg.sv
`timescale 1ns/1ps
package vps_pkg;
  localparam logic [5:0] DT_VSYNC_ON  = 6'h01;
  localparam logic [5:0] DT_VSYNC_OFF = 6'h11;
  localparam logic [5:0] DT_HSYNC_ON  = 6'h21;
  localparam logic [5:0] DT_HSYNC_OFF = 6'h31;
  localparam logic [5:0] DT_BLANK     = 6'h19;
  localparam logic [5:0] DT_PIX16     = 6'h0E;
  localparam logic [5:0] DT_PIX24     = 6'h3E;

  localparam int LINE_SLOTS = 6;

  typedef enum logic [2:0] {
    SL_SYNC = 3'd0,
    SL_HSW  = 3'd1,
    SL_HEND = 3'd2,
    SL_HBP  = 3'd3,
    SL_ACT  = 3'd4,
    SL_HFP  = 3'd5
  } slot_e;

  // byte count of a segment of npix pixels
  function automatic logic [15:0] seg_bytes(input logic [15:0] npix, input logic fmt24);
    seg_bytes = fmt24 ? 16'(npix + (npix << 1)) : 16'(npix << 1);
  endfunction

  // line lies inside [lo, lo+len)
  function automatic logic in_span(input logic [15:0] line, input logic [15:0] lo,
                                   input logic [15:0] len);
    logic [16:0] hi;
    hi = {1'b0, lo} + {1'b0, len};
    in_span = (line >= lo) && ({1'b0, line} < hi);
  endfunction
endpackage

// File: rtl/vps_cfg_shadow.sv
`timescale 1ns/1ps
module vps_cfg_shadow #(
  parameter int HW = 12,
  parameter int VW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [3:0][HW-1:0]  h_in,
  input  logic [3:0][VW-1:0]  v_in,
  input  logic                fmt_in,
  output logic [3:0][HW-1:0]  h_q,
  output logic [3:0][VW-1:0]  v_q,
  output logic                fmt_q
);
  for (genvar i = 0; i < 4; i++) begin : g_fld
    logic [HW-1:0] h_r;
    logic [VW-1:0] v_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        h_r <= '0;
        v_r <= '0;
      end else if (load) begin
        h_r <= h_in[i];
        v_r <= v_in[i];
      end
    end
    assign h_q[i] = h_r;
    assign v_q[i] = v_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    fmt_q <= 1'b0;
    else if (load) fmt_q <= fmt_in;
  end
endmodule

// File: rtl/vps_raster_cnt.sv
`timescale 1ns/1ps
module vps_raster_cnt #(
  parameter int LW    = 12,
  parameter int FW    = 16,
  parameter int SLOTS = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [LW-1:0] vtot,
  output logic [2:0]    slot,
  output logic [LW-1:0] line,
  output logic [FW-1:0] frame,
  output logic          line_end,
  output logic          wrap_evt
);
  localparam logic [2:0] LAST_SLOT = 3'(SLOTS - 1);

  logic last_line;
  assign last_line = (line == LW'(vtot - LW'(1)));
  assign line_end  = adv && (slot == LAST_SLOT);
  assign wrap_evt  = line_end && last_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot  <= '0;
      line  <= '0;
      frame <= '0;
    end else if (adv) begin
      if (slot == LAST_SLOT) begin
        slot <= '0;
        if (last_line) begin
          line  <= '0;
          frame <= frame + FW'(1);
        end else begin
          line <= line + LW'(1);
        end
      end else begin
        slot <= slot + 3'd1;
      end
    end
  end
endmodule

// File: rtl/vps_pkt_build.sv
`timescale 1ns/1ps
module vps_pkt_build
  import vps_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 10,
  parameter int LW = 12
) (
  input  logic [2:0]          slot,
  input  logic [LW-1:0]       line,
  input  logic [3:0][HW-1:0]  hcfg,
  input  logic [3:0][VW-1:0]  vcfg,
  input  logic                fmt24,
  output logic [5:0]          dtype,
  output logic                is_long,
  output logic [15:0]         field,
  output logic                is_pix
);
  logic        line_active;
  logic [15:0] act_lo;
  logic [5:0]  pix_dt;

  assign act_lo      = 16'(vcfg[0]) + 16'(vcfg[1]);
  assign line_active = in_span(16'(line), act_lo, 16'(vcfg[2]));
  assign pix_dt      = fmt24 ? DT_PIX24 : DT_PIX16;

  always_comb begin
    dtype   = DT_BLANK;
    is_long = 1'b1;
    field   = '0;
    is_pix  = 1'b0;
    case (slot_e'(slot))
      SL_SYNC: begin
        is_long = 1'b0;
        if (line == '0)                  dtype = DT_VSYNC_ON;
        else if (line == LW'(vcfg[0]))   dtype = DT_VSYNC_OFF;
        else                             dtype = DT_HSYNC_ON;
      end
      SL_HSW:  field = seg_bytes(16'(hcfg[0]), fmt24);
      SL_HEND: begin
        is_long = 1'b0;
        dtype   = DT_HSYNC_OFF;
      end
      SL_HBP:  field = seg_bytes(16'(hcfg[1]), fmt24);
      SL_ACT: begin
        field  = seg_bytes(16'(hcfg[2]), fmt24);
        is_pix = line_active;
        if (line_active) dtype = pix_dt;
      end
      SL_HFP:  field = seg_bytes(16'(hcfg[3]), fmt24);
      default: begin
        dtype   = DT_BLANK;
        is_long = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/vid_pkt_sched.sv
`timescale 1ns/1ps
module vid_pkt_sched
  import vps_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 10,
  parameter int FW = 16,
  localparam int LW = VW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] cfg_hsync,
  input  logic [HW-1:0] cfg_hbp,
  input  logic [HW-1:0] cfg_hact,
  input  logic [HW-1:0] cfg_hfp,
  input  logic [VW-1:0] cfg_vsync,
  input  logic [VW-1:0] cfg_vbp,
  input  logic [VW-1:0] cfg_vact,
  input  logic [VW-1:0] cfg_vfp,
  input  logic          cfg_fmt24,
  output logic          pkt_valid,
  input  logic          pkt_ready,
  output logic [5:0]    pkt_dtype,
  output logic          pkt_long,
  output logic [15:0]   pkt_field,
  output logic          pix_req,
  output logic          frame_start,
  output logic [LW-1:0] line_idx,
  output logic [FW-1:0] frame_cnt
);
  logic              valid_q;
  logic              accept;
  logic              frame_begin;
  logic              line_end;
  logic              wrap_evt;
  logic [2:0]        slot;
  logic [LW-1:0]     vtot;
  logic [3:0][HW-1:0] h_sh;
  logic [3:0][VW-1:0] v_sh;
  logic              fmt_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= 1'b1;
  end

  assign accept      = valid_q && pkt_ready;
  assign frame_begin = accept && (slot == 3'(SL_SYNC)) && (line_idx == '0);
  assign vtot        = LW'(v_sh[0]) + LW'(v_sh[1]) + LW'(v_sh[2]) + LW'(v_sh[3]);

  vps_cfg_shadow #(.HW(HW), .VW(VW)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (frame_begin),
    .h_in   ({cfg_hfp, cfg_hact, cfg_hbp, cfg_hsync}),
    .v_in   ({cfg_vfp, cfg_vact, cfg_vbp, cfg_vsync}),
    .fmt_in (cfg_fmt24),
    .h_q    (h_sh),
    .v_q    (v_sh),
    .fmt_q  (fmt_sh)
  );

  vps_raster_cnt #(.LW(LW), .FW(FW), .SLOTS(LINE_SLOTS)) u_raster (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (accept),
    .vtot     (vtot),
    .slot     (slot),
    .line     (line_idx),
    .frame    (frame_cnt),
    .line_end (line_end),
    .wrap_evt (wrap_evt)
  );

  logic is_pix;

  vps_pkt_build #(.HW(HW), .VW(VW), .LW(LW)) u_build (
    .slot    (slot),
    .line    (line_idx),
    .hcfg    (h_sh),
    .vcfg    (v_sh),
    .fmt24   (fmt_sh),
    .dtype   (pkt_dtype),
    .is_long (pkt_long),
    .field   (pkt_field),
    .is_pix  (is_pix)
  );

  assign pkt_valid   = valid_q;
  assign pix_req     = valid_q && is_pix;
  assign frame_start = frame_begin;
endmodule

// File: rtl/vps_chk.sv
`timescale 1ns/1ps
module vps_chk #(
  parameter int LW = 12,
  parameter int FW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pkt_valid,
  input logic          pkt_ready,
  input logic [5:0]    pkt_dtype,
  input logic          pkt_long,
  input logic [15:0]   pkt_field,
  input logic          pix_req,
  input logic          frame_start,
  input logic [LW-1:0] line_idx,
  input logic [FW-1:0] frame_cnt,
  input logic          wrap_evt,
  input logic          line_end
);
  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_dtype) && $stable(pkt_field)
                                && $stable(pkt_long) && $stable(line_idx));

  assert_short_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_long |-> pkt_field == 16'd0);

  assert_blank_is_long_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_dtype == 6'h19 |-> pkt_long);

  assert_frame_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> pkt_ready && line_idx == '0 && pkt_dtype == 6'h01);

  assert_pix_type_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req |-> pkt_long && (pkt_dtype == 6'h0E || pkt_dtype == 6'h3E));

  assert_frame_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt != $past(frame_cnt) |-> $past(wrap_evt) && frame_cnt == $past(frame_cnt) + FW'(1));

  assert_line_zero_after_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> line_idx == '0);

  assert_line_moves_on_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_idx != $past(line_idx) |-> $past(line_end));
endmodule

bind vid_pkt_sched vps_chk #(.LW(LW), .FW(FW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pkt_valid   (pkt_valid),
  .pkt_ready   (pkt_ready),
  .pkt_dtype   (pkt_dtype),
  .pkt_long    (pkt_long),
  .pkt_field   (pkt_field),
  .pix_req     (pix_req),
  .frame_start (frame_start),
  .line_idx    (line_idx),
  .frame_cnt   (frame_cnt),
  .wrap_evt    (wrap_evt),
  .line_end    (line_end)
);

// File: tb/vid_pkt_sched_tb.sv
`timescale 1ns/1ps
module vid_pkt_sched_tb;
  localparam int HW = 12;
  localparam int VW = 10;
  localparam int FW = 16;
  localparam int LW = VW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [HW-1:0] cfg_hsync, cfg_hbp, cfg_hact, cfg_hfp;
  logic [VW-1:0] cfg_vsync, cfg_vbp, cfg_vact, cfg_vfp;
  logic          cfg_fmt24;
  logic          pkt_valid;
  logic          pkt_ready = 1'b0;
  logic [5:0]    pkt_dtype;
  logic          pkt_long;
  logic [15:0]   pkt_field;
  logic          pix_req;
  logic          frame_start;
  logic [LW-1:0] line_idx;
  logic [FW-1:0] frame_cnt;

  always #10 clk = ~clk;

  vid_pkt_sched #(.HW(HW), .VW(VW), .FW(FW)) u_dut (.*);

  typedef struct {
    int    dt;
    bit    lng;
    int    field;
    int    line;
    int    frame;
    bit    pix;
    bit    vss;
    string tag;
  } exp_t;

  exp_t  q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  string ctx     = "";
  bit    vss_popped;
  bit    have_prev = 0;
  bit    prev_rdy  = 1;
  int    prev_dt, prev_field;
  bit    prev_long;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s%s %s: actual %0d expected %0d", tag, ctx, what, act, exp);
    end
  endtask

  task automatic push(input int dt, input bit lng, input int field, input int line,
                      input int frame, input bit pix, input bit vss, input string tag);
    exp_t e;
    e.dt = dt; e.lng = lng; e.field = field; e.line = line; e.frame = frame;
    e.pix = pix; e.vss = vss; e.tag = tag;
    q.push_back(e);
  endtask

  // expected commands of a frame after its vsync start, from the inputs at the accepting edge
  task automatic gen_frame(input int f);
    int bpp   = cfg_fmt24 ? 3 : 2;
    int pixdt = cfg_fmt24 ? 'h3E : 'h0E;
    int vs    = int'(cfg_vsync);
    int first = vs + int'(cfg_vbp);
    int vtot  = first + int'(cfg_vact) + int'(cfg_vfp);
    for (int ln = 0; ln < vtot; ln++) begin
      bit act = (ln >= first) && (ln < first + int'(cfg_vact));
      if (ln != 0) begin
        if (ln == vs) push('h11, 0, 0, ln, f, 0, 0, "R3");
        else          push('h21, 0, 0, ln, f, 0, 0, "R3");
      end
      push('h19, 1, int'(cfg_hsync) * bpp, ln, f, 0, 0, "R5");
      push('h31, 0, 0, ln, f, 0, 0, "R2");
      push('h19, 1, int'(cfg_hbp) * bpp, ln, f, 0, 0, "R5");
      if (act) push(pixdt, 1, int'(cfg_hact) * bpp, ln, f, 1, 0, "R4");
      else     push('h19, 1, int'(cfg_hact) * bpp, ln, f, 0, 0, "R4");
      push('h19, 1, int'(cfg_hfp) * bpp, ln, f, 0, 0, "R5");
    end
    push('h01, 0, 0, 0, (f + 1) % (1 << FW), 0, 1, "R6");
  endtask

  function automatic bit rdy_of(input int mode, input int c);
    case (mode)
      1:       rdy_of = (c % 3) != 1;
      2:       rdy_of = (c % 4) == 3;
      default: rdy_of = 1'b1;
    endcase
  endfunction

  task automatic step(input bit rdy);
    exp_t e;
    @(negedge clk);
    pkt_ready = rdy;
    #2;
    cyc++;
    vss_popped = 0;
    e = q[0];
    chk(pkt_valid == 1'b1, "R1", "pkt_valid", int'(pkt_valid), 1);
    chk(int'(pkt_dtype) == e.dt, e.tag, "pkt_dtype", int'(pkt_dtype), e.dt);
    chk(pkt_long == e.lng, "R2", "pkt_long", int'(pkt_long), int'(e.lng));
    chk(int'(pkt_field) == e.field, e.tag, "pkt_field", int'(pkt_field), e.field);
    chk(int'(line_idx) == e.line, "R6", "line_idx", int'(line_idx), e.line);
    chk(int'(frame_cnt) == e.frame, "R6", "frame_cnt", int'(frame_cnt), e.frame);
    chk(pix_req == e.pix, "R10", "pix_req", int'(pix_req), int'(e.pix));
    chk(frame_start == (rdy && e.vss), "R9", "frame_start", int'(frame_start), int'(rdy && e.vss));
    if (have_prev && !prev_rdy) begin
      // R8: stalled command must be presented again unchanged
      chk(int'(pkt_dtype) == prev_dt && int'(pkt_field) == prev_field && pkt_long == prev_long,
          "R8", "held command", int'(pkt_dtype), prev_dt);
    end
    have_prev  = 1;
    prev_rdy   = rdy;
    prev_dt    = int'(pkt_dtype);
    prev_field = int'(pkt_field);
    prev_long  = pkt_long;
    if (rdy) begin
      void'(q.pop_front());
      if (e.vss) begin
        vss_popped = 1;
        gen_frame(e.frame);
      end
    end
    @(posedge clk);
    #1;
  endtask

  task automatic run_frame(input int mode);
    bit started = 0;
    forever begin
      step(rdy_of(mode, cyc));
      if (vss_popped) started = 1;
      if (started && q[0].vss) break;
    end
  endtask

  task automatic set_cfg(input int hs, input int hb, input int ha, input int hf,
                         input int vs, input int vb, input int va, input int vf, input bit f24);
    cfg_hsync = HW'(hs); cfg_hbp = HW'(hb); cfg_hact = HW'(ha); cfg_hfp = HW'(hf);
    cfg_vsync = VW'(vs); cfg_vbp = VW'(vb); cfg_vact = VW'(va); cfg_vfp = VW'(vf);
    cfg_fmt24 = f24;
  endtask

  initial begin
    set_cfg(3, 2, 5, 1, 2, 1, 3, 1, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    chk(pkt_valid == 1'b0, "R1", "pkt_valid in reset", int'(pkt_valid), 0);
    chk(line_idx == '0, "R1", "line_idx in reset", int'(line_idx), 0);
    chk(frame_cnt == '0, "R1", "frame_cnt in reset", int'(frame_cnt), 0);
    chk(frame_start == 1'b0, "R9", "frame_start in reset", int'(frame_start), 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    push('h01, 0, 0, 0, 0, 0, 1, "R1");

    ctx = " 16-bit small";
    run_frame(0);

    // new timing and 24-bit format in the very cycle the vsync start is accepted
    ctx = " R7 change-at-accept";
    set_cfg(2, 4, 6, 3, 1, 2, 2, 2, 1'b1);
    run_frame(1);

    // mid-frame change must not disturb the frame in flight
    set_cfg(4, 1, 3, 2, 3, 1, 2, 1, 1'b1);
    ctx = " R7 mid-frame";
    repeat (25) step(rdy_of(1, cyc));
    set_cfg(1, 3, 4, 0, 1, 1, 4, 2, 1'b0);
    run_frame(1);
    ctx = " R7 next frame";
    run_frame(0);

    ctx = " default raster R4";
    set_cfg(96, 48, 640, 16, 2, 33, 480, 10, 1'b0);
    run_frame(0);

    ctx = " sparse ready R8";
    set_cfg(3, 2, 5, 1, 2, 1, 3, 1, 1'b1);
    run_frame(2);
    run_frame(2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule